// File: doc/BRIEF.md
# Sub-Range Synchronous Up Counter

This block is a synchronous up counter of parameterised width (four bits by default). It has a synchronous clear, a synchronous parallel load and a count enable. A carry output is high while the count sits at its all-ones value.

Two range inputs make the counter step through any sub-range instead of the full binary range:

- **Start value.** This value is placed into the count whenever an enabled cycle finds the count at all-ones, in place of the usual roll-over to zero.
- **End value.** This value is compared against the count. An enabled cycle that finds the count equal to it also returns the count to the start value.

With a start of zero and an end of all-ones, the block is a plain binary counter. Wider counters are built by cascading: the upper stage's enable is the lower stage's enable ANDed with the lower stage's carry.

All controls are sampled on the rising clock edge. A synchronous active-high reset returns the block to zero. Both the count and the carry leave the block straight from flip-flops.

Top module: `range_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next count is 0 and `carry_out` is 0.
- R2: `clr` high forces the count to 0 at the next edge, overriding `ld` and `en`.
- R3: `ld` high with `clr` low copies `ld_val` into the count at the next edge, whatever `en`, the count or the range inputs are.
- R4: With `clr` and `ld` low and `en` high, a count that equals neither `end_val` nor all-ones advances by exactly one.
- R5: With `clr`, `ld` and `en` all low, the count keeps its value, even when it equals `end_val` or all-ones.
- R6: `carry_out` is 1 in exactly those cycles in which the count is all ones (0xF at width 4), independent of `en`.
- R7: An enabled cycle (with `clr` and `ld` low) that finds the count at all-ones loads `start_val`; with `start_val` = 0110 the count runs 1111 then 0110.
- R8: An enabled cycle (with `clr` and `ld` low) that finds the count equal to `end_val` loads `start_val`; with start 0000 and end 1101 the sequence is 0000 through 1101, then 0000 again.
- R9: When `start_val` is above `end_val`, the count reloads `start_val` at whichever of `end_val` or all-ones it reaches first: with start 1010 and end 0101, a count loaded to 0011 runs 0100, 0101, 1010, …, 1111, 1010.
- R10: Two instances chained, the upper one enabled by the lower's `en` AND `carry_out`, both with start 0 and end all-ones, form a double-width binary counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear to zero |
| ld | input | 1 | Synchronous parallel load |
| ld_val | input | WIDTH | Value copied in by a load |
| en | input | 1 | Count enable |
| start_val | input | WIDTH | Value taken on wrap or end match |
| end_val | input | WIDTH | Early return point of the range |
| cnt | output | WIDTH | Registered count |
| carry_out | output | 1 | High while the count is all ones |

## Verification
The bench builds the counter at its default width of 4, so every one of the 16 states can be reached. Random start/end pairs therefore cover both ordered ranges and inverted ranges (start above end), together with collisions between the end value and all-ones.

A second 4-bit instance is chained onto the first through its carry. This brings the 8-bit cascade roll-over within a few hundred cycles. Directed runs pin down the stated sequences for a wrap to 0110 and an early end at 1101.

// File: rtl/range_counter_pkg.sv
package range_counter_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_CLEAR,
    ACT_LOAD,
    ACT_RELOAD,
    ACT_STEP
  } cnt_act_e;
endpackage

// File: rtl/range_counter_detect.sv
module range_counter_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] end_val,
  output logic             at_end,
  output logic             at_top
);
  // all-ones detect built as an AND chain over the bits
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign chain[i+1] = chain[i] & cnt[i];
  end
  assign at_top = chain[WIDTH];
  assign at_end = (cnt == end_val);
endmodule

// File: rtl/range_counter_next.sv
module range_counter_next
  import range_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clr,
  input  logic             ld,
  input  logic             en,
  input  logic             at_end,
  input  logic             at_top,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] ld_val,
  input  logic [WIDTH-1:0] start_val,
  output cnt_act_e         act,
  output logic [WIDTH-1:0] nxt
);
  always_comb begin
    if (clr)                    act = ACT_CLEAR;
    else if (ld)                act = ACT_LOAD;
    else if (!en)               act = ACT_HOLD;
    else if (at_end || at_top)  act = ACT_RELOAD;
    else                        act = ACT_STEP;
  end

  always_comb begin
    unique case (act)
      ACT_CLEAR:  nxt = '0;
      ACT_LOAD:   nxt = ld_val;
      ACT_RELOAD: nxt = start_val;
      ACT_STEP:   nxt = cnt + 1'b1;
      default:    nxt = cnt;
    endcase
  end
endmodule

// File: rtl/range_counter.sv
module range_counter
  import range_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             en,
  input  logic [WIDTH-1:0] start_val,
  input  logic [WIDTH-1:0] end_val,
  output logic [WIDTH-1:0] cnt,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             carry_q;
  logic             at_end;
  logic             at_top;
  cnt_act_e         act;

  range_counter_detect #(.WIDTH(WIDTH)) u_detect (
    .cnt     (cnt_q),
    .end_val (end_val),
    .at_end  (at_end),
    .at_top  (at_top)
  );

  range_counter_next #(.WIDTH(WIDTH)) u_next (
    .clr       (clr),
    .ld        (ld),
    .en        (en),
    .at_end    (at_end),
    .at_top    (at_top),
    .cnt       (cnt_q),
    .ld_val    (ld_val),
    .start_val (start_val),
    .act       (act),
    .nxt       (cnt_d)
  );

  // carry is registered from the next count so it lines up with cnt_q
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      carry_q <= (cnt_d == ALL_ONES);
    end
  end

  assign cnt       = cnt_q;
  assign carry_out = carry_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !carry_out);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLEAR) |=> (cnt == '0));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && ld) |=> (cnt == $past(ld_val)));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && en && (cnt != end_val) && (cnt != ALL_ONES))
      |=> (cnt == WIDTH'($past(cnt) + 1'b1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && !en) |=> $stable(cnt));

  // R6
  carry_match_chk: assert property (@(posedge clk) disable iff (rst)
    carry_out == (cnt == ALL_ONES));

  // R7 R8 R9
  reload_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && en && ((cnt == end_val) || (cnt == ALL_ONES)))
      |=> (cnt == $past(start_val)));
endmodule

// File: tb/range_counter_tb.sv
`timescale 1ns/1ps
module range_counter_tb;
  logic       clk = 1'b0;
  logic       rst, clr, ld, en;
  logic [3:0] ld_val, start_val, end_val, hi_ld_val;
  logic [3:0] cnt, hi_cnt;
  logic       carry_out, hi_carry;
  logic       hi_en;
  logic [3:0] exp_lo, exp_hi;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  range_counter #(.WIDTH(4)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .ld_val(ld_val), .en(en),
    .start_val(start_val), .end_val(end_val), .cnt(cnt), .carry_out(carry_out)
  );

  assign hi_en = en & carry_out;

  range_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .ld_val(hi_ld_val), .en(hi_en),
    .start_val(4'h0), .end_val(4'hF), .cnt(hi_cnt), .carry_out(hi_carry)
  );

  function automatic logic [3:0] model(input logic [3:0] cur, input logic c,
      input logic l, input logic [3:0] lv, input logic e,
      input logic [3:0] s, input logic [3:0] d);
    if (c)      return 4'h0;
    else if (l) return lv;
    else if (!e) return cur;
    else if (cur == d || cur == 4'hF) return s;
    else return cur + 4'h1;
  endfunction

  function automatic string tag(input logic [3:0] cur, input logic c,
      input logic l, input logic e, input logic [3:0] s, input logic [3:0] d);
    if (c)       return "R2";
    else if (l)  return "R3";
    else if (!e) return "R5";
    else if ((cur == d || cur == 4'hF) && s > d) return "R9";
    else if (cur == 4'hF) return "R7";
    else if (cur == d)    return "R8";
    else return "R4";
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic c, input logic l, input logic [3:0] lv,
      input logic e, input logic [3:0] s, input logic [3:0] d, input logic [3:0] hlv);
    string t;
    logic  hen;
    @(negedge clk);
    clr = c; ld = l; ld_val = lv; en = e; start_val = s; end_val = d; hi_ld_val = hlv;
    t   = tag(exp_lo, c, l, e, s, d);
    hen = e && (exp_lo == 4'hF);
    exp_hi = model(exp_hi, c, l, hlv, hen, 4'h0, 4'hF);
    exp_lo = model(exp_lo, c, l, lv, e, s, d);
    @(posedge clk);
    #1;
    check(t, {1'b0, cnt}, {1'b0, exp_lo});
    check("R6", {4'h0, carry_out}, {4'h0, exp_lo == 4'hF});
    check("R10", {1'b0, hi_cnt}, {1'b0, exp_hi});
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; clr = 0; ld = 0; en = 0;
    ld_val = 0; start_val = 0; end_val = 0; hi_ld_val = 0;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {1'b0, cnt}, 5'h0);
    check("R1", {4'h0, carry_out}, 5'h0);
    @(negedge clk);
    rst = 1'b0;
    exp_lo = 4'h0; exp_hi = 4'h0;

    // R8: 0..13 then back to 0
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 4'h0, 4'hD, 0);
    // R3 load 14 with enable high, then R7 wrap 15 -> 6
    cyc(0, 1, 4'hE, 1, 4'h6, 4'hF, 4'h0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 4'h6, 4'hF, 0);
    // R5 hold at end/all-ones with en low, carry stays (R6)
    cyc(0, 1, 4'hF, 0, 4'h6, 4'hF, 4'h0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 4'h6, 4'hF, 0);
    // R2 clear beats load and enable
    cyc(1, 1, 4'h9, 1, 4'h6, 4'hF, 4'h7);
    // R9 inverted range: start 10, end 5, from 3
    cyc(0, 1, 4'h3, 0, 4'hA, 4'h5, 4'h0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 4'hA, 4'h5, 0);
    // R10 cascade: 8-bit roll-over
    cyc(1, 0, 0, 0, 4'h0, 4'hF, 0);
    for (int i = 0; i < 260; i++) cyc(0, 0, 0, 1, 4'h0, 4'hF, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic c, l, e;
      c = ($urandom_range(0, 49) == 0);
      l = ($urandom_range(0, 19) == 0);
      e = ($urandom_range(0, 3) != 0);
      if (i % 64 == 0) begin
        start_val = 4'($urandom_range(0, 15));
        end_val   = 4'($urandom_range(0, 15));
      end
      cyc(c, l, 4'($urandom_range(0, 15)), e, start_val, end_val,
          4'($urandom_range(0, 15)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule